// File: doc/BRIEF.md
# SPI flash identification responder

This block behaves like the identification and status front end of a serial NOR flash. It sits on an SPI bus as a target device and answers the commands a host uses to find out what kind of flash is attached and what its status is. The host drives chip select, the serial clock and the MOSI line, and the block drives MISO. Three configuration inputs supply the manufacturer code, the memory type code and the device code that the block reports.

The block keeps an 8-bit status byte. Bit 0 is a busy flag, bit 1 is the write-enable latch, bits 5:2 are four block-protect bits, bit 6 is a continuous-program mode flag and bit 7 is a status-write-disable flag. The host can set and clear the write-enable latch, and it can rewrite the upper six bits through a status-write command. There is no memory array and no program or erase timing, so the busy flag always reads 0.

The SPI pins are sampled by the block's own clock through synchronizers. The serial clock must therefore run several times slower than the system clock. The bus uses mode 0: the serial clock idles low, MOSI is sampled on the rising edge, and MISO changes after the falling edge.

Top module: `flash_id_responder`

## Requirements
- R1: After opcode 0x9F, the next three bytes on MISO are the manufacturer code, the memory type code and the device code, in that order. Any later byte in the same transfer reads 0x00.
- R2: After opcode 0xAB, MISO reads 0x00 during the next three (dummy) bytes. The fifth byte of the transfer carries the device code.
- R3: After opcode 0x90, MISO reads 0x00 during the next three bytes: two dummy bytes, then a selector byte. When the selector is 0x00, the fifth byte carries the manufacturer code and the sixth byte carries the device code.
- R4: After opcode 0x90 with a nonzero selector byte (such as 0x01), the fifth byte carries the device code and the sixth byte carries the manufacturer code.
- R5: After opcode 0x05, every following byte repeats the current status byte for as long as chip select stays low. Bit 0 (busy) reads 0. The status byte is 0x00 after reset.
- R6: Opcode 0x06 sets the write-enable latch (status bit 1). Opcode 0x04 clears it.
- R7: Opcode 0x01 followed by at least one full data byte, sent while the write-enable latch is set, takes effect when chip select rises. Status bits 7:2 take the first data byte's bits 7:2, and the write-enable latch clears. Bits 1:0 of the data byte are not written. A second data byte is accepted but discarded.
- R8: A status write is ignored, and status bits 7:2 and the write-enable latch keep their values, when the write-enable latch is clear or when no full data byte follows the opcode.
- R9: MISO shifts out MSB first and changes only after a falling edge of the serial clock. It reads 0 after reset, while chip select is high, and during the opcode byte.
- R10: After any opcode other than 0x9F, 0xAB, 0x90, 0x05, 0x01, 0x06 and 0x04, MISO stays 0 until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sck_i | input | 1 | SPI serial clock from the host (mode 0) |
| spi_cs_n_i | input | 1 | Active-low chip select from the host |
| spi_mosi_i | input | 1 | Serial data from the host |
| spi_miso_o | output | 1 | Serial data to the host |
| cfg_mfr_id_i | input | 8 | Manufacturer code to report |
| cfg_mem_type_i | input | 8 | Memory type code to report |
| cfg_dev_id_i | input | 8 | Device code to report |

## Verification
The assertions assume the SPI pins are slow compared with the system clock. Each serial clock level and each MOSI value must last long enough that the synchronizers see exactly one rising and one falling edge per bit. Chip select must only change while the serial clock is low. The bench meets this by holding every serial clock phase for eight system clocks and by changing MOSI and chip select only while the serial clock is low. It also waits ten clocks between transfers, so that a status commit at chip select release is finished before the next command arrives.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_READ_ID   = 8'h9F;
  localparam logic [BYTE_W-1:0] OP_WAKE_ID   = 8'hAB;
  localparam logic [BYTE_W-1:0] OP_MFR_DEV   = 8'h90;
  localparam logic [BYTE_W-1:0] OP_STAT_RD   = 8'h05;
  localparam logic [BYTE_W-1:0] OP_STAT_WR   = 8'h01;
  localparam logic [BYTE_W-1:0] OP_WR_ENA    = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WR_DIS    = 8'h04;

  // Bits of the status byte that a status write may change (7:2).
  localparam logic [BYTE_W-1:0] STAT_WR_MASK = 8'hFC;
  localparam int               WEL_BIT      = 1;

  function automatic logic opcode_known(input logic [BYTE_W-1:0] op);
    return (op == OP_READ_ID) || (op == OP_WAKE_ID) || (op == OP_MFR_DEV) ||
           (op == OP_STAT_RD) || (op == OP_STAT_WR) || (op == OP_WR_ENA) ||
           (op == OP_WR_DIS);
  endfunction
endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_active_o,
  output logic cs_rise_o,
  output logic mosi_o
);
  // Lane order inside each stage: {mosi, cs_n, sck}
  localparam int              LANES     = 3;
  localparam logic [LANES-1:0] LANE_RST = 3'b010;

  logic [LANES-1:0] stage_q [SYNC_STAGES];
  logic             sck_d_q;
  logic             cs_n_d_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    logic [LANES-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = {mosi_i, cs_n_i, sck_i};
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= LANE_RST;
      else        stage_q[g] <= stage_d;
    end
  end

  logic sck_s, cs_n_s;
  assign sck_s  = stage_q[SYNC_STAGES-1][0];
  assign cs_n_s = stage_q[SYNC_STAGES-1][1];
  assign mosi_o = stage_q[SYNC_STAGES-1][2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q  <= 1'b0;
      cs_n_d_q <= 1'b1;
    end else begin
      sck_d_q  <= sck_s;
      cs_n_d_q <= cs_n_s;
    end
  end

  assign cs_active_o = !cs_n_s;
  assign sck_rise_o  = sck_s && !sck_d_q && !cs_n_s;
  assign sck_fall_o  = !sck_s && sck_d_q && !cs_n_s;
  assign cs_rise_o   = cs_n_s && !cs_n_d_q;
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_id_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              cs_active_i,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [BYTE_W-1:0] mfr_id_i,
  input  logic [BYTE_W-1:0] mem_type_i,
  input  logic [BYTE_W-1:0] dev_id_i,
  output logic              byte_done_o,
  output logic [CNT_W-1:0]  byte_idx_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [BYTE_W-1:0] opcode_o,
  output logic              miso_o
);
  localparam int               BIT_W   = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [BIT_W-1:0]  bit_cnt_q,  bit_cnt_d;
  logic [CNT_W-1:0]  byte_cnt_q, byte_cnt_d;
  logic [BYTE_W-2:0] rx_sh_q,    rx_sh_d;
  logic [BYTE_W-1:0] opcode_q,   opcode_d;
  logic              dev_first_q, dev_first_d;
  logic [BYTE_W-1:0] tx_sh_q,    tx_sh_d;
  logic              miso_q,     miso_d;

  logic [BYTE_W-1:0] byte_full;
  logic              byte_done;
  logic [BYTE_W-1:0] resp;

  assign byte_full = {rx_sh_q, mosi_i};
  assign byte_done = sck_rise_i && (bit_cnt_q == BIT_TOP);

  // Byte to present for the byte slot that starts next.
  always_comb begin
    resp = '0;
    case (opcode_q)
      OP_READ_ID: begin
        if      (byte_cnt_q == CNT_W'(1)) resp = mfr_id_i;
        else if (byte_cnt_q == CNT_W'(2)) resp = mem_type_i;
        else if (byte_cnt_q == CNT_W'(3)) resp = dev_id_i;
      end
      OP_WAKE_ID: begin
        if (byte_cnt_q == CNT_W'(4)) resp = dev_id_i;
      end
      OP_MFR_DEV: begin
        if      (byte_cnt_q == CNT_W'(4)) resp = dev_first_q ? dev_id_i : mfr_id_i;
        else if (byte_cnt_q == CNT_W'(5)) resp = dev_first_q ? mfr_id_i : dev_id_i;
      end
      OP_STAT_RD: begin
        if (byte_cnt_q != '0) resp = status_i;
      end
      default: resp = '0;
    endcase
  end

  always_comb begin
    bit_cnt_d   = bit_cnt_q;
    byte_cnt_d  = byte_cnt_q;
    rx_sh_d     = rx_sh_q;
    opcode_d    = opcode_q;
    dev_first_d = dev_first_q;
    tx_sh_d     = tx_sh_q;
    miso_d      = miso_q;
    if (!cs_active_i) begin
      bit_cnt_d   = '0;
      byte_cnt_d  = '0;
      rx_sh_d     = '0;
      opcode_d    = '0;
      dev_first_d = 1'b0;
      tx_sh_d     = '0;
      miso_d      = 1'b0;
    end else begin
      if (sck_rise_i) begin
        rx_sh_d   = byte_full[BYTE_W-2:0];
        bit_cnt_d = bit_cnt_q + 1'b1;
        if (byte_done) begin
          if (byte_cnt_q != CNT_MAX) byte_cnt_d = byte_cnt_q + 1'b1;
          if (byte_cnt_q == '0) opcode_d = byte_full;
          if ((opcode_q == OP_MFR_DEV) && (byte_cnt_q == CNT_W'(3)))
            dev_first_d = |byte_full;
        end
      end
      if (sck_fall_i) begin
        if (bit_cnt_q == '0) begin
          miso_d  = resp[BYTE_W-1];
          tx_sh_d = {resp[BYTE_W-2:0], 1'b0};
        end else begin
          miso_d  = tx_sh_q[BYTE_W-1];
          tx_sh_d = {tx_sh_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q   <= '0;
      byte_cnt_q  <= '0;
      rx_sh_q     <= '0;
      opcode_q    <= '0;
      dev_first_q <= 1'b0;
      tx_sh_q     <= '0;
      miso_q      <= 1'b0;
    end else begin
      bit_cnt_q   <= bit_cnt_d;
      byte_cnt_q  <= byte_cnt_d;
      rx_sh_q     <= rx_sh_d;
      opcode_q    <= opcode_d;
      dev_first_q <= dev_first_d;
      tx_sh_q     <= tx_sh_d;
      miso_q      <= miso_d;
    end
  end

  assign byte_done_o = byte_done;
  assign byte_idx_o  = byte_cnt_q;
  assign rx_byte_o   = byte_full;
  assign opcode_o    = opcode_q;
  assign miso_o      = miso_q;

  // R9: MISO moves only on a serial clock fall or when deselected.
  assert_miso_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_q) |-> $past(sck_fall_i || !cs_active_i));

  // R9: MISO is low throughout the opcode byte.
  assert_miso_quiet_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active_i && byte_cnt_q == '0) |-> !miso_q);

  // R10: an unrecognised opcode keeps MISO low for the rest of the transfer.
  assert_unknown_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_cnt_q != '0 && !opcode_known(opcode_q)) |-> !miso_q);
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_id_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done_i,
  input  logic [CNT_W-1:0]  byte_idx_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [BYTE_W-1:0] opcode_i,
  input  logic              cs_rise_i,
  output logic [BYTE_W-1:0] status_o
);
  logic [BYTE_W-1:0] stat_q, stat_d;
  logic [BYTE_W-1:0] pend_q, pend_d;
  logic              pend_vld_q, pend_vld_d;
  logic              commit;

  assign commit = cs_rise_i && pend_vld_q && stat_q[WEL_BIT];

  always_comb begin
    stat_d     = stat_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    if (byte_done_i) begin
      if (byte_idx_i == '0) begin
        if (rx_byte_i == OP_WR_ENA) stat_d[WEL_BIT] = 1'b1;
        if (rx_byte_i == OP_WR_DIS) stat_d[WEL_BIT] = 1'b0;
      end
      if ((byte_idx_i == CNT_W'(1)) && (opcode_i == OP_STAT_WR)) begin
        pend_d     = rx_byte_i;
        pend_vld_d = 1'b1;
      end
    end
    if (cs_rise_i) begin
      pend_vld_d = 1'b0;
      if (commit) begin
        stat_d          = (pend_q & STAT_WR_MASK) | (stat_q & ~STAT_WR_MASK);
        stat_d[WEL_BIT] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q     <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      stat_q     <= stat_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  assign status_o = stat_q;

  // R6: the write-enable opcode leaves the latch set.
  assert_wel_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_i && byte_idx_i == '0 && rx_byte_i == OP_WR_ENA) |=> stat_q[WEL_BIT]);

  // R7: an accepted status write loads bits 7:2 and drops the latch.
  assert_commit_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i && pend_vld_q && stat_q[WEL_BIT]) |=>
      (!stat_q[WEL_BIT] && stat_q[7:2] == $past(pend_q[7:2])));

  // R8: protect and mode bits change only through an accepted write.
  assert_prot_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_q[7:2]) |-> $past(cs_rise_i && pend_vld_q && stat_q[WEL_BIT]));
endmodule

// File: rtl/flash_id_responder.sv
module flash_id_responder
  import flash_id_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int CNT_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck_i,
  input  logic              spi_cs_n_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  input  logic [BYTE_W-1:0] cfg_mfr_id_i,
  input  logic [BYTE_W-1:0] cfg_mem_type_i,
  input  logic [BYTE_W-1:0] cfg_dev_id_i
);
  logic              rst_n_s;
  logic              sck_rise, sck_fall, cs_active, cs_rise, mosi_s;
  logic              byte_done;
  logic [CNT_W-1:0]  byte_idx;
  logic [BYTE_W-1:0] rx_byte, opcode, status;

  flash_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) pin_sync_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .sck_i       (spi_sck_i),
    .cs_n_i      (spi_cs_n_i),
    .mosi_i      (spi_mosi_i),
    .sck_rise_o  (sck_rise),
    .sck_fall_o  (sck_fall),
    .cs_active_o (cs_active),
    .cs_rise_o   (cs_rise),
    .mosi_o      (mosi_s)
  );

  flash_cmd_engine #(.CNT_W(CNT_W)) cmd_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .sck_rise_i  (sck_rise),
    .sck_fall_i  (sck_fall),
    .cs_active_i (cs_active),
    .mosi_i      (mosi_s),
    .status_i    (status),
    .mfr_id_i    (cfg_mfr_id_i),
    .mem_type_i  (cfg_mem_type_i),
    .dev_id_i    (cfg_dev_id_i),
    .byte_done_o (byte_done),
    .byte_idx_o  (byte_idx),
    .rx_byte_o   (rx_byte),
    .opcode_o    (opcode),
    .miso_o      (spi_miso_o)
  );

  flash_status_reg #(.CNT_W(CNT_W)) stat_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .byte_done_i (byte_done),
    .byte_idx_i  (byte_idx),
    .rx_byte_i   (rx_byte),
    .opcode_i    (opcode),
    .cs_rise_i   (cs_rise),
    .status_o    (status)
  );
endmodule

// File: tb/flash_id_responder_tb_top.sv
module flash_id_responder_tb_top;
  localparam int HALF_BIT = 8;
  localparam logic [7:0] MFR  = 8'hC2;
  localparam logic [7:0] MTYP = 8'h20;
  localparam logic [7:0] DEV  = 8'h17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  bit         chk_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];

  always #2 clk = ~clk;

  flash_id_responder dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .spi_sck_i      (sck),
    .spi_cs_n_i     (cs_n),
    .spi_mosi_i     (mosi),
    .spi_miso_o     (miso),
    .cfg_mfr_id_i   (MFR),
    .cfg_mem_type_i (MTYP),
    .cfg_dev_id_i   (DEV)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      wait_clk(HALF_BIT);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(HALF_BIT);
      sck = 1'b0;
    end
  endtask

  // Driver: queue expectation, then clock the byte and hand the result over.
  task automatic xfer(input logic [7:0] tx, input bit chk, input logic [7:0] exp, input string tag);
    logic [7:0] rx;
    exp_q.push_back(exp);
    chk_q.push_back(chk);
    tag_q.push_back(tag);
    spi_bits(tx, 8, rx);
    act_q.push_back(rx);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(HALF_BIT);
  endtask

  task automatic desel();
    wait_clk(HALF_BIT);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(10);
  endtask

  task automatic read_status(input logic [7:0] exp, input int n, input string tag);
    sel();
    xfer(8'h05, 1'b1, 8'h00, "R9 opcode byte quiet");
    for (int i = 0; i < n; i++) xfer(8'h00, 1'b1, exp, tag);
    desel();
  endtask

  task automatic one_op(input logic [7:0] op);
    sel();
    xfer(op, 1'b0, 8'h00, "");
    desel();
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        logic [7:0] a, e;
        bit c;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        c = chk_q.pop_front();
        t = tag_q.pop_front();
        if (c) begin
          checks++;
          if (a !== e) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", t, a, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    checks++;
    if (miso !== 1'b0) begin
      failures++;
      $display("FAIL R9 reset miso actual=%0b expected=0", miso);
    end

    // R1 identification read
    sel();
    xfer(8'h9F, 1'b1, 8'h00, "R9 opcode byte quiet");
    xfer(8'h00, 1'b1, MFR,   "R1 manufacturer");
    xfer(8'h00, 1'b1, MTYP,  "R1 memory type");
    xfer(8'h00, 1'b1, DEV,   "R1 device");
    xfer(8'h00, 1'b1, 8'h00, "R1 trailing byte");
    desel();

    // R2 wake-and-identify with three dummies
    sel();
    xfer(8'hAB, 1'b0, 8'h00, "");
    for (int i = 0; i < 3; i++) xfer(8'h00, 1'b1, 8'h00, "R2 dummy quiet");
    xfer(8'h00, 1'b1, DEV, "R2 device in fifth byte");
    desel();

    // R3 selector 0x00
    sel();
    xfer(8'h90, 1'b0, 8'h00, "");
    xfer(8'h00, 1'b1, 8'h00, "R3 dummy quiet");
    xfer(8'h00, 1'b1, 8'h00, "R3 dummy quiet");
    xfer(8'h00, 1'b1, 8'h00, "R3 selector quiet");
    xfer(8'h00, 1'b1, MFR,   "R3 first manufacturer");
    xfer(8'h00, 1'b1, DEV,   "R3 then device");
    desel();

    // R4 selector 0x01
    sel();
    xfer(8'h90, 1'b0, 8'h00, "");
    xfer(8'h00, 1'b0, 8'h00, "");
    xfer(8'h00, 1'b0, 8'h00, "");
    xfer(8'h01, 1'b1, 8'h00, "R4 selector quiet");
    xfer(8'h00, 1'b1, DEV,   "R4 first device");
    xfer(8'h00, 1'b1, MFR,   "R4 then manufacturer");
    desel();

    // R5 status after reset, repeated
    read_status(8'h00, 3, "R5 status repeat after reset");

    // R6 latch set and clear
    one_op(8'h06);
    read_status(8'h02, 2, "R6 latch set");
    one_op(8'h04);
    read_status(8'h00, 1, "R6 latch cleared");

    // R8 write without latch ignored
    sel(); xfer(8'h01, 1'b0, 8'h00, ""); xfer(8'hFC, 1'b0, 8'h00, ""); desel();
    read_status(8'h00, 1, "R8 write without latch");

    // R7 accepted write, bits 1:0 not written, latch dropped
    one_op(8'h06);
    sel(); xfer(8'h01, 1'b0, 8'h00, ""); xfer(8'hFF, 1'b0, 8'h00, ""); desel();
    read_status(8'hFC, 2, "R7 write all ones");

    // R7 second data byte discarded
    one_op(8'h06);
    sel();
    xfer(8'h01, 1'b0, 8'h00, "");
    xfer(8'h54, 1'b0, 8'h00, "");
    xfer(8'hAA, 1'b0, 8'h00, "");
    desel();
    read_status(8'h54, 1, "R7 first byte kept");

    // R8 opcode only, then partial data byte: nothing taken, latch stays
    one_op(8'h06);
    one_op(8'h01);
    read_status(8'h56, 1, "R8 no data byte");
    begin
      logic [7:0] junk;
      sel();
      xfer(8'h01, 1'b0, 8'h00, "");
      spi_bits(8'h00, 4, junk);
      desel();
    end
    read_status(8'h56, 1, "R8 partial data byte");

    // R10 unknown opcode while status is nonzero
    sel();
    xfer(8'h3C, 1'b1, 8'h00, "R10 opcode quiet");
    for (int i = 0; i < 3; i++) xfer(8'h00, 1'b1, 8'h00, "R10 unknown stays low");
    desel();

    // R1 again after other traffic
    sel();
    xfer(8'h9F, 1'b0, 8'h00, "");
    xfer(8'h00, 1'b1, MFR, "R1 repeat manufacturer");
    desel();

    wait_clk(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule